// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh

This block keeps an asynchronous DRAM's contents alive. It brings the memory up after power-on: it waits out a start-up pause, then clocks a run of row-strobe-only dummy cycles, and only after that reports the memory ready. From then on an interval timer marks when refresh is due. The block asks the access controller for the strobe bus through a request/grant handshake. Once it holds the bus, it drives CAS-before-RAS refresh cycles. In these cycles the DRAM supplies the row address, so the address and data pins are not driven.

A parameter picks the refresh style. In distributed style one refresh cycle is due per interval (period divided by rows). In burst style one tick per period asks for all rows back to back.

A level-sensitive low-power request moves the DRAM into self refresh and back out. Exit from self refresh follows the chosen style. In burst style a full burst is run before the bus is handed back. In distributed style no burst is run. Ticks that arrive while the controller withholds the grant are counted, and an error flag shows when the count exceeds a parameterized limit.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, RAS and both CAS outputs are high, `ready_o`, `req_o` and `err_o` are low, and `busy_o` is high.
- R2: After reset release the strobes stay high for exactly INIT_PAUSE_CYC cycles. Then exactly INIT_CYCLES RAS pulses follow with both CAS high, each RAS low for TRAS_CYC cycles and high for TRP_CYC cycles after it. `ready_o` rises when the last precharge ends, and `busy_o` stays high until then.
- R3: In distributed mode, with prompt grants, `req_o` rises once every REF_PERIOD_CYC/ROWS cycles.
- R4: Whenever `busy_o` is low, RAS and both CAS are high. After a grant, `busy_o` goes high and the strobes stay high for TRP_CYC cycles before the first strobe falls.
- R5: A refresh cycle lowers both CAS together. RAS falls TCSR_CYC cycles later, and both stay low for TRAS_CYC cycles. All strobes then rise together and stay high for TRP_CYC cycles before `busy_o` drops. Only one RAS pulse occurs per grant in distributed mode.
- R6: Each interval tick that is not yet served adds one to a pending count. `err_o` is high exactly while the count exceeds PEND_MAX, so with no grants it rises PEND_MAX*interval-1 cycles after `req_o` rises. Each grant serves and removes one pending tick, and `err_o` clears once the backlog is served.
- R7: If a grant arrives with nothing pending and `lp_req_i` high, the block enters self refresh. Both CAS fall, then RAS falls TCSR_CYC cycles later. RAS stays low for TRASS_CYC cycles, or for as long as `lp_req_i` stays high if that is longer.
- R8: On self-refresh exit the strobes rise together and stay high with `busy_o` set for TRPS_CYC cycles. In distributed mode `busy_o` then drops with no further RAS pulse in that grant.
- R9: In burst mode `req_o` rises once every REF_PERIOD_CYC cycles, and each refresh grant produces exactly ROWS back-to-back refresh cycles.
- R10: In burst mode, after the self-refresh exit precharge, exactly ROWS refresh cycles run before `busy_o` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_req_i | input | 1 | Level request to hold the DRAM in self refresh |
| gnt_i | input | 1 | Access controller hands the strobe bus over (sampled while `req_o` is high) |
| req_o | output | 1 | Request for the strobe bus |
| ras_n_o | output | 1 | Row strobe, active low, valid while `busy_o` is high |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| busy_o | output | 1 | Block owns the strobe bus |
| ready_o | output | 1 | Power-on initialization finished |
| err_o | output | 1 | Pending refresh count above limit |

## Verification
The strobes, `busy_o` and `req_o` are decoded from the registered state. They therefore change in the cycle that follows the deciding clock edge. The bench samples on falling edges and measures each strobe phase as a count of samples, so every phase length is compared exactly with its parameter. A tick is registered into the pending count one edge after it occurs, and `req_o` follows one edge later, while `err_o` follows the count in the same cycle. This gives the bench an exact expected gap between a request rising and the error rising. The periods between requests are also taken from request rise to request rise, with grants always given on the first sample of a request, so the grant latency cancels out.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [3:0] {
    S_PAUSE,
    S_INIT_LO,
    S_INIT_HI,
    S_IDLE,
    S_REQ,
    S_PRE,
    S_CBR_CAS,
    S_CBR_RAS,
    S_CBR_PRE,
    S_SR_CAS,
    S_SR_HOLD,
    S_SR_EXIT
  } ref_st_e;
endpackage

// File: rtl/dram_ref_tick.sv
module dram_ref_tick #(
  parameter int unsigned TICK_CYC = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(TICK_CYC + 1);

  logic [TW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == TW'(TICK_CYC - 1));
  assign tick_o = en_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !en_i)   cnt_q <= '0;
    else if (wrap)             cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (TICK_CYC > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dram_ref_pend.sv
module dram_ref_pend #(
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic nz_o,
  output logic err_o
);
  localparam int unsigned SAT = PEND_MAX + 1;
  localparam int unsigned PW  = $clog2(SAT + 1);

  logic [PW-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (clr_i) pend_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (pend_q != PW'(SAT)) pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0)       pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign nz_o  = (pend_q != '0);
  assign err_o = (pend_q > PW'(PEND_MAX));

  // R6
  pend_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_i && !clr_i && (pend_q < PW'(SAT)) |=> pend_q == PW'($past(pend_q) + 1'b1));
  // R6
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(inc_i));
endmodule

// File: rtl/dram_ref_fsm.sv
module dram_ref_fsm
  import dram_ref_pkg::*;
#(
  parameter int unsigned INIT_PAUSE_CYC = 20000,
  parameter int unsigned INIT_CYCLES    = 8,
  parameter int unsigned ROWS           = 512,
  parameter bit          BURST_MODE     = 1'b0,
  parameter int unsigned TRAS_CYC       = 6,
  parameter int unsigned TRP_CYC        = 4,
  parameter int unsigned TCSR_CYC       = 1,
  parameter int unsigned TRASS_CYC      = 10,
  parameter int unsigned TRPS_CYC       = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_nz_i,
  input  logic lp_req_i,
  input  logic gnt_i,
  output logic req_o,
  output logic busy_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic pend_dec_o,
  output logic sr_o
);
  localparam int unsigned CW = $clog2(INIT_PAUSE_CYC + TRAS_CYC + TRP_CYC + TCSR_CYC
                                      + TRASS_CYC + TRPS_CYC + 2);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
  localparam int unsigned RW = $clog2(ROWS + 1);
  localparam int unsigned JOB_ROWS = BURST_MODE ? ROWS : 1;

  function automatic logic [CW-1:0] dur(input int unsigned n);
    return CW'(n - 1);
  endfunction

  ref_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] ic_q, ic_d;
  logic [RW-1:0] rows_q, rows_d;
  logic          sr_job_q, sr_job_d;
  logic          post_q, post_d;
  logic          rdy_q, rdy_d;
  logic          done;

  assign done = (cnt_q == '0);

  always_comb begin
    st_d     = st_q;
    cnt_d    = done ? cnt_q : cnt_q - 1'b1;
    ic_d     = ic_q;
    rows_d   = rows_q;
    sr_job_d = sr_job_q;
    post_d   = post_q;
    rdy_d    = rdy_q;
    unique case (st_q)
      S_PAUSE:   if (done) begin st_d = S_INIT_LO; cnt_d = dur(TRAS_CYC); end
      S_INIT_LO: if (done) begin st_d = S_INIT_HI; cnt_d = dur(TRP_CYC); end
      S_INIT_HI: if (done) begin
        if (ic_q == IW'(INIT_CYCLES - 1)) begin
          st_d  = S_IDLE;
          rdy_d = 1'b1;
        end else begin
          ic_d  = ic_q + 1'b1;
          st_d  = S_INIT_LO;
          cnt_d = dur(TRAS_CYC);
        end
      end
      S_IDLE: if (pend_nz_i || lp_req_i) st_d = S_REQ;
      S_REQ: begin
        if (gnt_i) begin
          st_d     = S_PRE;
          cnt_d    = dur(TRP_CYC);
          sr_job_d = !pend_nz_i;            // pending refresh wins over low power
          post_d   = 1'b0;
          rows_d   = RW'(JOB_ROWS);
        end else if (!pend_nz_i && !lp_req_i) begin
          st_d = S_IDLE;
        end
      end
      S_PRE: if (done) begin
        st_d  = sr_job_q ? S_SR_CAS : S_CBR_CAS;
        cnt_d = dur(TCSR_CYC);
      end
      S_CBR_CAS: if (done) begin st_d = S_CBR_RAS; cnt_d = dur(TRAS_CYC); end
      S_CBR_RAS: if (done) begin st_d = S_CBR_PRE; cnt_d = dur(TRP_CYC); end
      S_CBR_PRE: if (done) begin
        if (rows_q == RW'(1)) begin
          st_d   = S_IDLE;
          post_d = 1'b0;
        end else begin
          rows_d = rows_q - 1'b1;
          st_d   = S_CBR_CAS;
          cnt_d  = dur(TCSR_CYC);
        end
      end
      S_SR_CAS:  if (done) begin st_d = S_SR_HOLD; cnt_d = dur(TRASS_CYC); end
      S_SR_HOLD: if (done && !lp_req_i) begin st_d = S_SR_EXIT; cnt_d = dur(TRPS_CYC); end
      S_SR_EXIT: if (done) begin
        if (BURST_MODE) begin
          post_d = 1'b1;
          rows_d = RW'(ROWS);
          st_d   = S_CBR_CAS;
          cnt_d  = dur(TCSR_CYC);
        end else begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_PAUSE;
      cnt_q    <= CW'(INIT_PAUSE_CYC);  // reset cycle counts toward the pause
      ic_q     <= '0;
      rows_q   <= '0;
      sr_job_q <= 1'b0;
      post_q   <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      ic_q     <= ic_d;
      rows_q   <= rows_d;
      sr_job_q <= sr_job_d;
      post_q   <= post_d;
      rdy_q    <= rdy_d;
    end
  end

  assign ready_o    = rdy_q;
  assign req_o      = (st_q == S_REQ);
  assign busy_o     = !(st_q inside {S_IDLE, S_REQ});
  assign ras_n_o    = !(st_q inside {S_INIT_LO, S_CBR_RAS, S_SR_HOLD});
  assign cas_n_o    = !(st_q inside {S_CBR_CAS, S_CBR_RAS, S_SR_CAS, S_SR_HOLD});
  assign pend_dec_o = (st_q == S_CBR_PRE) && done && (rows_q == RW'(1)) && !post_q;
  assign sr_o       = (st_q inside {S_SR_CAS, S_SR_HOLD, S_SR_EXIT}) || post_q;

  // checker-side count of cycles spent with RAS held in self refresh
  logic [CW-1:0] hold_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hold_cnt_q <= '0;
    else if (st_q != S_SR_HOLD)   hold_cnt_q <= '0;
    else if (hold_cnt_q != '1)    hold_cnt_q <= hold_cnt_q + 1'b1;
  end

  // R2
  init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> busy_o && !req_o && cas_n_o);
  // R4
  grant_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$past(busy_o) |-> $past(gnt_i) && $past(req_o));
  // R4
  idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ras_n_o && cas_n_o);
  // R5
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) && ready_o |-> !cas_n_o && $past(!cas_n_o));
  // R5
  cbr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) && ready_o |-> $rose(cas_n_o));
  // R7
  sr_hold_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(st_q == S_SR_HOLD) && (st_q != S_SR_HOLD) |-> $past(hold_cnt_q) >= CW'(TRASS_CYC - 1));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned INIT_PAUSE_CYC = 20000,
  parameter int unsigned INIT_CYCLES    = 8,
  parameter int unsigned ROWS           = 512,
  parameter int unsigned REF_PERIOD_CYC = 800000,
  parameter bit          BURST_MODE     = 1'b0,
  parameter int unsigned TRAS_CYC       = 6,
  parameter int unsigned TRP_CYC        = 4,
  parameter int unsigned TCSR_CYC       = 1,
  parameter int unsigned TRASS_CYC      = 10,
  parameter int unsigned TRPS_CYC       = 11,
  parameter int unsigned PEND_MAX       = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_req_i,
  input  logic gnt_i,
  output logic req_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic busy_o,
  output logic ready_o,
  output logic err_o
);
  localparam int unsigned TICK_CYC = BURST_MODE ? REF_PERIOD_CYC : REF_PERIOD_CYC / ROWS;

  logic tick, pend_nz, pend_dec, sr_act, cas_n;

  dram_ref_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ready_o),
    .clr_i  (sr_act),
    .tick_o (tick)
  );

  dram_ref_pend #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (pend_dec),
    .clr_i  (sr_act),
    .nz_o   (pend_nz),
    .err_o  (err_o)
  );

  dram_ref_fsm #(
    .INIT_PAUSE_CYC (INIT_PAUSE_CYC),
    .INIT_CYCLES    (INIT_CYCLES),
    .ROWS           (ROWS),
    .BURST_MODE     (BURST_MODE),
    .TRAS_CYC       (TRAS_CYC),
    .TRP_CYC        (TRP_CYC),
    .TCSR_CYC       (TCSR_CYC),
    .TRASS_CYC      (TRASS_CYC),
    .TRPS_CYC       (TRPS_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_nz_i  (pend_nz),
    .lp_req_i   (lp_req_i),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n),
    .pend_dec_o (pend_dec),
    .sr_o       (sr_act)
  );

  // both byte strobes move together: refresh never selects a byte
  assign lcas_n_o = cas_n;
  assign ucas_n_o = cas_n;
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE  = 20;
  localparam int NINIT  = 8;
  localparam int ROWS   = 8;
  localparam int PERIOD = 400;
  localparam int TICK   = PERIOD / ROWS;
  localparam int TRAS   = 3;
  localparam int TRP    = 2;
  localparam int TCSR   = 1;
  localparam int TRASS  = 10;
  localparam int TRPS   = 4;
  localparam int PMAX   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt_r = 1'b0, lp_r = 1'b0, sel = 1'b0;
  int   n_run = 0, n_fail = 0, viol = 0, cyc = 0;

  logic req_a, ras_a, lcas_a, ucas_a, busy_a, rdy_a, err_a;
  logic req_b, ras_b, lcas_b, ucas_b, busy_b, rdy_b, err_b;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched #(
    .INIT_PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .ROWS(ROWS), .REF_PERIOD_CYC(PERIOD),
    .BURST_MODE(1'b0), .TRAS_CYC(TRAS), .TRP_CYC(TRP), .TCSR_CYC(TCSR),
    .TRASS_CYC(TRASS), .TRPS_CYC(TRPS), .PEND_MAX(PMAX)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .lp_req_i(lp_r && !sel), .gnt_i(gnt_r && !sel),
    .req_o(req_a), .ras_n_o(ras_a), .lcas_n_o(lcas_a), .ucas_n_o(ucas_a),
    .busy_o(busy_a), .ready_o(rdy_a), .err_o(err_a)
  );

  dram_refresh_sched #(
    .INIT_PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .ROWS(ROWS), .REF_PERIOD_CYC(PERIOD),
    .BURST_MODE(1'b1), .TRAS_CYC(TRAS), .TRP_CYC(TRP), .TCSR_CYC(TCSR),
    .TRASS_CYC(TRASS), .TRPS_CYC(TRPS), .PEND_MAX(PMAX)
  ) dut_burst (
    .clk_i(clk), .rst_ni(rst_n), .lp_req_i(lp_r && sel), .gnt_i(gnt_r && sel),
    .req_o(req_b), .ras_n_o(ras_b), .lcas_n_o(lcas_b), .ucas_n_o(ucas_b),
    .busy_o(busy_b), .ready_o(rdy_b), .err_o(err_b)
  );

  wire req_w  = sel ? req_b  : req_a;
  wire ras_w  = sel ? ras_b  : ras_a;
  wire cas_w  = sel ? lcas_b : lcas_a;
  wire busy_w = sel ? busy_b : busy_a;
  wire err_w  = sel ? err_b  : err_a;

  // R4 ownership monitor on both instances
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy_a && (!ras_a || !lcas_a || !ucas_a)) viol++;
      if (!busy_b && (!ras_b || !lcas_b || !ucas_b)) viol++;
      if (lcas_a != ucas_a || lcas_b != ucas_b) viol++;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_req(output int t);
    int k = 0;
    while (!req_w && k < 3000) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic grant_measure(input int drop_at, output int pre, output int csr,
                               output int lo, output int post, output int nf);
    bit pr = 1'b1;
    int ph = 0;
    int k = 0;
    pre = 0; csr = 0; lo = 0; post = 0; nf = 0;
    gnt_r = 1'b1;
    @(negedge clk);
    gnt_r = 1'b0;
    while (busy_w && k < 5000) begin
      if (ph == 0 && !(ras_w && cas_w)) ph = 1;
      if (ph == 1 && !ras_w) ph = 2;
      if (ph == 2 && ras_w) ph = 3;
      case (ph)
        0: pre++;
        1: csr++;
        2: lo++;
        default: post++;
      endcase
      if (pr && !ras_w) nf++;
      pr = ras_w;
      if (ph == 2 && drop_at != 0 && lo == drop_at) lp_r = 1'b0;
      @(negedge clk);
      k++;
    end
  endtask

  task automatic serve_all(output int n);
    int a, b, c, d, e;
    n = 0;
    forever begin
      int k = 0;
      while (!req_w && k < 3) begin @(negedge clk); k++; end
      if (!req_w) break;
      grant_measure(0, a, b, c, d, e);
      n++;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(ras_a && lcas_a && ucas_a, "R1 strobes high in reset", ras_a, 1);
    chk(!rdy_a && !req_a && !err_a, "R1 ready/req/err low in reset", rdy_a + req_a + err_a, 0);
    chk(busy_a, "R1 busy high in reset", busy_a, 1);
  endtask

  task automatic t_init;
    int pause = 0, pulses = 0, badw = 0, cas_lo = 0, cur = 0, k = 0, busy_lo = 0;
    bit seen = 1'b0, pr = 1'b1;
    rst_n = 1'b1;
    while (!rdy_a && k < 2000) begin
      @(negedge clk);
      k++;
      if (!ras_a) seen = 1'b1;
      if (!seen) pause++;
      if (!lcas_a) cas_lo++;
      if (!busy_a && !rdy_a) busy_lo++;
      if (pr && !ras_a) begin pulses++; cur = 0; end
      if (!ras_a) cur++;
      if (!pr && ras_a && cur != TRAS) badw++;
      pr = ras_a;
    end
    chk(pause == PAUSE, "R2 start-up pause length", pause, PAUSE);
    chk(pulses == NINIT, "R2 dummy RAS pulse count", pulses, NINIT);
    chk(badw == 0, "R2 dummy RAS low width", badw, 0);
    chk(cas_lo == 0 && busy_lo == 0, "R2 CAS high and busy held in init", cas_lo + busy_lo, 0);
    chk(rdy_a && rdy_b, "R2 ready after init", rdy_a + rdy_b, 2);
  endtask

  task automatic t_cbr;
    int t1, t2, pre, csr, lo, post, nf;
    wait_req(t1);
    grant_measure(0, pre, csr, lo, post, nf);
    chk(pre == TRP, "R4 precharge after grant", pre, TRP);
    chk(csr == TCSR, "R5 CAS lead before RAS", csr, TCSR);
    chk(lo == TRAS, "R5 RAS low width", lo, TRAS);
    chk(post == TRP, "R5 precharge before release", post, TRP);
    chk(nf == 1, "R5 one RAS pulse per grant", nf, 1);
    wait_req(t2);
    chk(t2 - t1 == TICK, "R3 distributed request interval", t2 - t1, TICK);
    grant_measure(0, pre, csr, lo, post, nf);
  endtask

  task automatic t_pend;
    int t0, k = 0, n;
    wait_req(t0);
    while (!err_w && k < 1000) begin @(negedge clk); k++; end
    chk(cyc - t0 == PMAX * TICK - 1, "R6 error rise time", cyc - t0, PMAX * TICK - 1);
    serve_all(n);
    chk(n == PMAX + 1, "R6 one refresh per pending tick", n, PMAX + 1);
    chk(!err_w, "R6 error clears after backlog", err_w, 0);
  endtask

  task automatic t_sr;
    int t, pre, csr, lo, post, nf;
    wait_req(t);
    grant_measure(0, pre, csr, lo, post, nf);
    lp_r = 1'b1;
    wait_req(t);
    grant_measure(2, pre, csr, lo, post, nf);
    chk(pre == TRP && csr == TCSR, "R7 CAS falls before RAS on entry", csr, TCSR);
    chk(lo == TRASS, "R7 minimum self-refresh RAS low", lo, TRASS);
    chk(post == TRPS, "R8 exit precharge length", post, TRPS);
    chk(nf == 1, "R8 no burst after distributed exit", nf, 1);
    lp_r = 1'b1;
    wait_req(t);
    grant_measure(25, pre, csr, lo, post, nf);
    chk(lo == 25, "R7 RAS held while low-power request stays", lo, 25);
    chk(viol == 0, "R4 strobes high whenever not owned", viol, 0);
  endtask

  task automatic t_burst;
    int t1, t2, n, pre, csr, lo, post, nf;
    sel = 1'b1;
    @(negedge clk);
    wait_req(t1);
    grant_measure(0, pre, csr, lo, post, nf);
    chk(nf == ROWS, "R9 burst refresh count", nf, ROWS);
    chk(pre == TRP && csr == TCSR, "R9 burst starts with precharge and CAS lead", pre, TRP);
    serve_all(n);
    wait_req(t1);
    grant_measure(0, pre, csr, lo, post, nf);
    wait_req(t2);
    chk(t2 - t1 == PERIOD, "R9 burst request period", t2 - t1, PERIOD);
    grant_measure(0, pre, csr, lo, post, nf);
    lp_r = 1'b1;
    wait_req(t1);
    grant_measure(2, pre, csr, lo, post, nf);
    chk(lo == TRASS, "R10 self-refresh hold in burst mode", lo, TRASS);
    chk(nf == ROWS + 1, "R10 burst after self-refresh exit", nf, ROWS + 1);
    chk(viol == 0, "R4 strobes high whenever not owned (burst)", viol, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_cbr();
    t_pend();
    t_sr();
    t_burst();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule